// File: doc/BRIEF.md
# Trace-aligned hint store

This block keeps one small history record (a hint) for each instruction slot of each line in a set-associative trace store. It sits next to the instruction array and uses the same set and way coordinates, so one access returns the whole line of hints, every slot in parallel. The only reads come from fetch on a trace hit. The only writes are full hint lines from the trace builder, and one arrives every time a trace completes, even when the same line is already held.

A write cannot reach the storage in a cycle in which fetch reads the same set. Such a write is parked in a short pending queue and retires in a later cycle when the read targets a different set. The writer is never back-pressured. A write that cannot proceed raises `wr_stall` for that cycle, is queued, and completes on its own. If the queue is full and its oldest entry is still blocked when another write arrives, that oldest entry is discarded and a drop counter advances. When a line is evicted it is invalidated. Its hints are then gone, and a later read returns freshly zeroed hints.

Hint slot `i` of a line occupies bits `[i*HINT_W +: HINT_W]` of a line bus.

Top module: `hint_trace_store`

## Requirements
- R1: After reset every way of every set is invalid, `drop_count` is 0, and a read returns `rd_line_ok` = 0 with all-zero hints.
- R2: A read presented with `rd_en` at a rising edge gives `rd_vld` = 1 on the next cycle. That cycle also carries `rd_line_ok` and the full hint line held at that set and way, with slot `i` in bits `[i*HINT_W +: HINT_W]`.
- R3: A write with an empty pending queue, whose set differs from the read set of that cycle (or with no read), is stored at that edge with `wr_stall` = 0. It is readable, valid, from the next read on.
- R4: A write whose set equals the set read in the same cycle is held back (`wr_stall` = 1). It is stored in the first later cycle whose read, if any, targets another set. A write to a different set in a reading cycle is not held back.
- R5: Queued writes are never forwarded. A read of a line with a write still queued returns the line's previous contents.
- R6: While the pending queue holds entries, an arriving write is queued behind them (`wr_stall` = 1). Queued writes retire oldest first, at most one per cycle, so the later write to a line is the one that remains.
- R7: The queue holds `PEND` entries. A write arriving when the queue is full and its oldest entry cannot retire discards that oldest entry, and `drop_count` goes up by exactly 1.
- R8: `inv_en` clears the valid state of one set and way, so later reads give `rd_line_ok` = 0 and zero hints. It also cancels any queued write to that same set and way.
- R9: A write stored in the same cycle as an invalidate of the same set and way leaves the line valid with the new hints.
- R10: A write to a line that is already valid replaces all of its hints.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Fetch hit: read the hint line at rd_set/rd_way |
| rd_set | input | clog2(SETS) | Read set index |
| rd_way | input | clog2(WAYS) | Read way select |
| rd_vld | output | 1 | Read result valid (one cycle after rd_en) |
| rd_line_ok | output | 1 | The line read was valid |
| rd_hints | output | SLOTS*HINT_W | Hint line read (zero if the line was invalid) |
| wr_valid | input | 1 | Hint line write from the trace builder |
| wr_set | input | clog2(SETS) | Write set index |
| wr_way | input | clog2(WAYS) | Write way |
| wr_hints | input | SLOTS*HINT_W | Hint line to store |
| wr_stall | output | 1 | The current write was queued instead of stored |
| inv_en | input | 1 | Eviction: invalidate inv_set/inv_way |
| inv_set | input | clog2(SETS) | Invalidate set index |
| inv_way | input | clog2(WAYS) | Invalidate way |
| drop_count | output | DROP_W | Number of queued writes discarded |

## Verification
The assertions cover the rules that hold in every cycle:
- the storage never receives a write and a read to the same set together;
- read results appear exactly one cycle after the request;
- an arriving write is stalled whenever the queue is not empty;
- an invalidate leaves its line invalid unless a write to it lands in the same cycle;
- a drop happens only from a full queue, and the counter moves only then, by one.

Only the bench scenarios can show what ends up in the storage: the data, the order in which queued writes retire, which entry a drop removes, the cancellation of queued writes by eviction, and the old data returned while a write waits. The bench does this by filling a small configuration entirely with computed patterns and reading every line back.

// File: rtl/hint_store_pkg.sv
package hint_store_pkg;
  localparam int unsigned HS_SETS   = 512;
  localparam int unsigned HS_WAYS   = 4;
  localparam int unsigned HS_SLOTS  = 16;
  localparam int unsigned HS_HINT_W = 8;
  localparam int unsigned HS_PEND   = 2;
  localparam int unsigned HS_DROP_W = 16;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hint_line_store.sv
module hint_line_store #(
  parameter int unsigned SETS   = 512,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned SW    = hint_store_pkg::idx_w(SETS),
  localparam int unsigned WW    = hint_store_pkg::idx_w(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [SW-1:0]     rd_set_i,
  input  logic [WW-1:0]     rd_way_i,
  input  logic              we_i,
  input  logic [SW-1:0]     wr_set_i,
  input  logic [WW-1:0]     wr_way_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              inv_i,
  input  logic [SW-1:0]     inv_set_i,
  input  logic [WW-1:0]     inv_way_i,
  output logic              rd_vld_o,
  output logic              rd_ok_o,
  output logic [LINE_W-1:0] rd_line_o
);
  localparam int unsigned ENT = SETS * WAYS;
  localparam int unsigned IW  = hint_store_pkg::idx_w(ENT);

  logic [LINE_W-1:0] mem_q [ENT];
  logic [ENT-1:0]    valid_q;

  function automatic logic [IW-1:0] flat(input logic [SW-1:0] s, input logic [WW-1:0] w);
    return IW'(s) * IW'(WAYS) + IW'(w);
  endfunction

  logic [IW-1:0] r_idx, w_idx, i_idx;
  assign r_idx = flat(rd_set_i, rd_way_i);
  assign w_idx = flat(wr_set_i, wr_way_i);
  assign i_idx = flat(inv_set_i, inv_way_i);

  always_ff @(posedge clk) begin
    if (we_i) mem_q[w_idx] <= wr_line_i;
  end

  // Valid bits: the write comes after the invalidate, so a write wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (inv_i) valid_q[i_idx] <= 1'b0;
      if (we_i)  valid_q[w_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_o  <= 1'b0;
      rd_ok_o   <= 1'b0;
      rd_line_o <= '0;
    end else begin
      rd_vld_o <= rd_en_i;
      if (rd_en_i) begin
        rd_ok_o   <= valid_q[r_idx];
        rd_line_o <= valid_q[r_idx] ? mem_q[r_idx] : '0;
      end
    end
  end

  // R4: storage never sees a read and a write to one set in the same cycle
  assert_no_same_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && rd_en_i) |-> (wr_set_i != rd_set_i));

  // R8: an invalidate with no same-line write leaves that line invalid
  assert_inv_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_i && !(we_i && w_idx == i_idx)) |=> !valid_q[$past(i_idx)]);
endmodule

// File: rtl/hint_pend_queue.sv
module hint_pend_queue #(
  parameter int unsigned SW     = 9,
  parameter int unsigned WW     = 2,
  parameter int unsigned LINE_W = 128,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [SW-1:0]     push_set_i,
  input  logic [WW-1:0]     push_way_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic              pop_i,
  input  logic              cancel_i,
  input  logic [SW-1:0]     cancel_set_i,
  input  logic [WW-1:0]     cancel_way_i,
  output logic              head_vld_o,
  output logic [SW-1:0]     head_set_o,
  output logic [WW-1:0]     head_way_o,
  output logic [LINE_W-1:0] head_line_o,
  output logic              drop_o
);
  typedef struct packed {
    logic [SW-1:0]     s;
    logic [WW-1:0]     w;
    logic [LINE_W-1:0] d;
  } ent_t;

  ent_t           q_q [DEPTH];
  ent_t           k   [DEPTH];
  logic [CW-1:0]  cnt_q, cnt_d;
  int             fill_n;

  always_comb begin
    fill_n = 0;
    for (int j = 0; j < DEPTH; j++) k[j] = '0;
    // Compact the surviving entries after eviction cancels.
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(cnt_q) &&
          !(cancel_i && q_q[i].s == cancel_set_i && q_q[i].w == cancel_way_i)) begin
        for (int j = 0; j < DEPTH; j++) if (j == fill_n) k[j] = q_q[i];
        fill_n++;
      end
    end
    head_vld_o  = (fill_n != 0);
    head_set_o  = k[0].s;
    head_way_o  = k[0].w;
    head_line_o = k[0].d;
    if (pop_i && fill_n != 0) begin
      for (int j = 0; j < DEPTH - 1; j++) k[j] = k[j+1];
      k[DEPTH-1] = '0;
      fill_n--;
    end
    drop_o = 1'b0;
    if (push_i) begin
      if (fill_n == DEPTH) begin
        for (int j = 0; j < DEPTH - 1; j++) k[j] = k[j+1];
        k[DEPTH-1] = '0;
        fill_n--;
        drop_o = 1'b1;
      end
      for (int j = 0; j < DEPTH; j++)
        if (j == fill_n) k[j] = '{s: push_set_i, w: push_way_i, d: push_line_i};
      fill_n++;
    end
    cnt_d = CW'(fill_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= k[i];
    end
  end

  // R7: a discard only happens from a queue that was full
  assert_drop_from_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/hint_trace_store.sv
module hint_trace_store #(
  parameter int unsigned SETS   = hint_store_pkg::HS_SETS,
  parameter int unsigned WAYS   = hint_store_pkg::HS_WAYS,
  parameter int unsigned SLOTS  = hint_store_pkg::HS_SLOTS,
  parameter int unsigned HINT_W = hint_store_pkg::HS_HINT_W,
  parameter int unsigned PEND   = hint_store_pkg::HS_PEND,
  parameter int unsigned DROP_W = hint_store_pkg::HS_DROP_W,
  localparam int unsigned SW     = hint_store_pkg::idx_w(SETS),
  localparam int unsigned WW     = hint_store_pkg::idx_w(WAYS),
  localparam int unsigned LINE_W = SLOTS * HINT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [SW-1:0]     rd_set,
  input  logic [WW-1:0]     rd_way,
  output logic              rd_vld,
  output logic              rd_line_ok,
  output logic [LINE_W-1:0] rd_hints,
  input  logic              wr_valid,
  input  logic [SW-1:0]     wr_set,
  input  logic [WW-1:0]     wr_way,
  input  logic [LINE_W-1:0] wr_hints,
  output logic              wr_stall,
  input  logic              inv_en,
  input  logic [SW-1:0]     inv_set,
  input  logic [WW-1:0]     inv_way,
  output logic [DROP_W-1:0] drop_count
);
  logic              head_vld, drop;
  logic [SW-1:0]     head_set;
  logic [WW-1:0]     head_way;
  logic [LINE_W-1:0] head_line;
  logic              issue_head, direct, push;
  logic              st_we;
  logic [SW-1:0]     st_set;
  logic [WW-1:0]     st_way;
  logic [LINE_W-1:0] st_line;

  // One storage write per cycle; the queue head has priority over new writes.
  assign issue_head = head_vld && !(rd_en && head_set == rd_set);
  assign direct     = wr_valid && !head_vld && !(rd_en && wr_set == rd_set);
  assign push       = wr_valid && !direct;
  assign wr_stall   = push;

  assign st_we   = issue_head || direct;
  assign st_set  = issue_head ? head_set  : wr_set;
  assign st_way  = issue_head ? head_way  : wr_way;
  assign st_line = issue_head ? head_line : wr_hints;

  hint_pend_queue #(.SW(SW), .WW(WW), .LINE_W(LINE_W), .DEPTH(PEND)) pend_i (
    .clk, .rst_n,
    .push_i(push), .push_set_i(wr_set), .push_way_i(wr_way), .push_line_i(wr_hints),
    .pop_i(issue_head),
    .cancel_i(inv_en), .cancel_set_i(inv_set), .cancel_way_i(inv_way),
    .head_vld_o(head_vld), .head_set_o(head_set), .head_way_o(head_way),
    .head_line_o(head_line), .drop_o(drop)
  );

  hint_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) store_i (
    .clk, .rst_n,
    .rd_en_i(rd_en), .rd_set_i(rd_set), .rd_way_i(rd_way),
    .we_i(st_we), .wr_set_i(st_set), .wr_way_i(st_way), .wr_line_i(st_line),
    .inv_i(inv_en), .inv_set_i(inv_set), .inv_way_i(inv_way),
    .rd_vld_o(rd_vld), .rd_ok_o(rd_line_ok), .rd_line_o(rd_hints)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    drop_count <= '0;
    else if (drop) drop_count <= drop_count + 1'b1;
  end

  // R2: read result follows the request by exactly one cycle
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);

  // R6: a write arriving behind queued entries is never stored directly
  assert_queue_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && head_vld) |-> wr_stall);

  // R7: the drop counter moves only on a stalled write, by one
  assert_drop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |->
      ($past(wr_valid && wr_stall) && drop_count == $past(drop_count) + 1'b1));
endmodule

// File: tb/hint_trace_store_tb_top.sv
module hint_trace_store_tb_top;
  localparam int SETS = 8, WAYS = 4, SLOTS = 4, HW = 8, PEND = 2, DW = 8;
  localparam int LW = SLOTS * HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0, wr_valid = 1'b0, inv_en = 1'b0;
  logic [2:0]    rd_set = '0, wr_set = '0, inv_set = '0;
  logic [1:0]    rd_way = '0, wr_way = '0, inv_way = '0;
  logic [LW-1:0] wr_hints = '0;
  logic          rd_vld, rd_line_ok, wr_stall;
  logic [LW-1:0] rd_hints;
  logic [DW-1:0] drop_count;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic last_stall;

  always #2.5 clk = ~clk;

  hint_trace_store #(.SETS(SETS), .WAYS(WAYS), .SLOTS(SLOTS), .HINT_W(HW),
                     .PEND(PEND), .DROP_W(DW)) dut_i (
    .clk, .rst_n, .rd_en, .rd_set, .rd_way, .rd_vld, .rd_line_ok, .rd_hints,
    .wr_valid, .wr_set, .wr_way, .wr_hints, .wr_stall,
    .inv_en, .inv_set, .inv_way, .drop_count);

  function automatic logic [LW-1:0] pat(input int s, input int w, input int seed);
    logic [LW-1:0] r;
    for (int j = 0; j < SLOTS; j++) r[j*HW +: HW] = HW'((s*16 + w*4 + j*3 + seed*29) & 255);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge; returns at the next falling edge.
  task automatic step(input bit re, input int rs, input int rw,
                      input bit we, input int ws, input int ww, input logic [LW-1:0] wd,
                      input bit ie, input int is, input int iw);
    rd_en = re; rd_set = 3'(rs); rd_way = 2'(rw);
    wr_valid = we; wr_set = 3'(ws); wr_way = 2'(ww); wr_hints = wd;
    inv_en = ie; inv_set = 3'(is); inv_way = 2'(iw);
    #1 last_stall = wr_stall;
    @(negedge clk);
    rd_en = 1'b0; wr_valid = 1'b0; inv_en = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, '0, 0, 0, 0);
  endtask

  task automatic rd_chk(input string req, input int s, input int w, input bit ok_e, input logic [LW-1:0] d_e);
    step(1, s, w, 0, 0, 0, '0, 0, 0, 0);
    chk(rd_vld == 1'b1 && rd_line_ok == ok_e, req, LW'({rd_vld, rd_line_ok}), LW'({1'b1, ok_e}));
    chk(rd_hints == d_e, req, rd_hints, d_e);
  endtask

  task automatic stall_chk(input string req, input bit exp);
    chk(last_stall == exp, req, LW'(last_stall), LW'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(drop_count == 0, "R1 drop count", LW'(drop_count), '0);
    rd_chk("R1 empty read", 0, 0, 1'b0, '0);
    rd_chk("R1 empty read", 7, 3, 1'b0, '0);

    // R3: fill every line with no competing read, then R2: read all back
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        step(0, 0, 0, 1, s, w, pat(s, w, 1), 0, 0, 0);
        stall_chk("R3 direct write", 1'b0);
      end
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) rd_chk("R2 sweep read", s, w, 1'b1, pat(s, w, 1));

    // R10: overwrite a valid line
    step(0, 0, 0, 1, 2, 1, pat(2, 1, 7), 0, 0, 0);
    rd_chk("R10 overwrite", 2, 1, 1'b1, pat(2, 1, 7));

    // R4: same-set conflict is deferred; other set goes through
    step(1, 3, 0, 1, 3, 2, pat(3, 2, 9), 0, 0, 0);
    stall_chk("R4 same set stalls", 1'b1);
    chk(rd_hints == pat(3, 0, 1), "R4 read beside stall", rd_hints, pat(3, 0, 1));
    idle();
    rd_chk("R4 deferred write landed", 3, 2, 1'b1, pat(3, 2, 9));
    step(1, 2, 0, 1, 5, 3, pat(5, 3, 12), 0, 0, 0);
    stall_chk("R4 other set not stalled", 1'b0);
    chk(rd_hints == pat(2, 0, 1), "R4 read other set", rd_hints, pat(2, 0, 1));
    rd_chk("R4 other set stored", 5, 3, 1'b1, pat(5, 3, 12));

    // R5: a queued write is not visible to reads
    step(1, 5, 1, 1, 5, 1, pat(5, 1, 11), 0, 0, 0);
    stall_chk("R5 stall", 1'b1);
    chk(rd_hints == pat(5, 1, 1), "R5 old data", rd_hints, pat(5, 1, 1));
    rd_chk("R5 still old while queued", 5, 1, 1'b1, pat(5, 1, 1));
    idle();
    rd_chk("R5 new after retire", 5, 1, 1'b1, pat(5, 1, 11));

    // R6: ordering through the queue
    step(1, 6, 0, 1, 6, 0, pat(6, 0, 3), 0, 0, 0);
    stall_chk("R6 first queued", 1'b1);
    step(1, 6, 1, 1, 6, 0, pat(6, 0, 4), 0, 0, 0);
    stall_chk("R6 second queued", 1'b1);
    step(0, 0, 0, 1, 1, 3, pat(1, 3, 5), 0, 0, 0);
    stall_chk("R6 queued behind entries", 1'b1);
    idle();
    idle();
    rd_chk("R6 later write remains", 6, 0, 1'b1, pat(6, 0, 4));
    rd_chk("R6 third write retired", 1, 3, 1'b1, pat(1, 3, 5));
    chk(drop_count == 0, "R6 no drop", LW'(drop_count), '0);

    // R7: overflow discards the oldest
    step(1, 4, 0, 1, 4, 0, pat(4, 0, 20), 0, 0, 0);
    step(1, 4, 0, 1, 4, 1, pat(4, 1, 21), 0, 0, 0);
    chk(drop_count == 0, "R7 no drop yet", LW'(drop_count), '0);
    step(1, 4, 0, 1, 4, 2, pat(4, 2, 22), 0, 0, 0);
    chk(drop_count == 1, "R7 drop counted", LW'(drop_count), LW'(1));
    idle();
    idle();
    rd_chk("R7 oldest dropped", 4, 0, 1'b1, pat(4, 0, 1));
    rd_chk("R7 kept entry", 4, 1, 1'b1, pat(4, 1, 21));
    rd_chk("R7 newest entry", 4, 2, 1'b1, pat(4, 2, 22));
    chk(drop_count == 1, "R7 drop count stable", LW'(drop_count), LW'(1));

    // R8: invalidate, and cancel of a queued write
    step(0, 0, 0, 0, 0, 0, '0, 1, 7, 3);
    rd_chk("R8 invalidated line", 7, 3, 1'b0, '0);
    step(1, 7, 0, 1, 7, 2, pat(7, 2, 30), 0, 0, 0);
    stall_chk("R8 write queued", 1'b1);
    step(1, 7, 0, 0, 0, 0, '0, 1, 7, 2);
    idle();
    idle();
    rd_chk("R8 queued write cancelled", 7, 2, 1'b0, '0);
    rd_chk("R8 neighbour untouched", 7, 1, 1'b1, pat(7, 1, 1));

    // R9: write and invalidate of one line in one cycle
    step(0, 0, 0, 1, 0, 1, pat(0, 1, 40), 1, 0, 1);
    rd_chk("R9 write wins", 0, 1, 1'b1, pat(0, 1, 40));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule